// File: doc/BRIEF.md
# Packed SIMD Multiply Unit

This block is a pipelined multiplier for a media datapath. Each cycle it may take one pair of 32-bit source words and an operation code. It returns either a 32-bit result or a 64-bit result split into a low word and a high word. The operation code selects one of several forms:

- a scalar product
- a half-word by word product
- lane-parallel half-word or byte products
- sums of products
- a complex product of two packed 16-bit complex numbers, either at full precision or rounded and packed
- a carry-less product in GF(2^8), taken separately in each byte lane

A separate sign input chooses signed or unsigned treatment for the integer forms. The complex forms are always signed.

The unit has two register stages. The first stage forms every partial product the operation code might need. The second stage combines those products, rounds and saturates where the form requires it, and places the result into the low/high word pair. A new operation may enter every cycle. No operation stays inside the unit for more than two cycles, so there are no held states or stalls. The pipeline has three named occupancy conditions:

- IDLE: neither stage holds a valid operation.
- FILL: only stage 1 holds one.
- FLOW: stage 2 holds one.

Each condition moves to the next on the next edge, following the valid bits.

Top module: `simd_mul_unit`

## Requirements
- R1: Op 0 (word product): {res_hi,res_lo} is the 64-bit product of src_a and src_b. It is two's-complement signed when in_signed=1 and unsigned when in_signed=0. The low 32 bits go to res_lo and the upper 32 bits go to res_hi.
- R2: Op 1: src_a[15:0] (extended per in_signed) times src_b (extended per in_signed). The result is given as a 64-bit pair.
- R3: Op 2: res_lo = src_a[15:0]*src_b[15:0] and res_hi = src_a[31:16]*src_b[31:16]. Each is a 32-bit product, signed or unsigned per in_signed.
- R4: Op 3: src_a[15:0]*src_b and src_a[31:16]*src_b are each formed as 48-bit products. Bits [47:16] of the first go to res_lo and bits [47:16] of the second go to res_hi.
- R5: Op 4: four byte-lane 16-bit products, signed or unsigned per in_signed. Lane k is src_a[8k+7:8k]*src_b[8k+7:8k]. res_lo = {lane1,lane0} and res_hi = {lane3,lane2}.
- R6: Ops 5 and 6: res_lo is (high-half product) plus (op 5) or minus (op 6) the low-half product, modulo 2^32. res_hi = 0.
- R7: Op 7: res_lo is the sum of all four byte-lane products, extended per in_signed, modulo 2^32. res_hi = 0.
- R8: Op 8 (complex): each operand holds its real part in [31:16] and its imaginary part in [15:0]. res_lo = ar*br - ai*bi and res_hi = ar*bi + ai*br. Both are signed and taken modulo 2^32.
- R9: Op 9 (rounded complex): add 0x8000 to each exact complex part, shift right arithmetically by 16, and saturate to [-32768, 32767]. res_lo = {real16, imag16} and res_hi = 0.
- R10: Op 10: each byte lane of res_lo is the GF(2^8) product of the matching lanes, reduced by x^8+x^4+x^3+x^2+1. res_hi = 0.
- R11: An operation presented with in_valid high appears with out_valid high exactly two edges later. Operations may be issued on consecutive cycles. out_valid is low, and both result words are zero, in any cycle that has no result.
- R12: Op codes 11 to 15 give a valid result of zero in both words.
- R13: While rst_n is low, out_valid, res_lo and res_hi are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair and op code are valid this cycle |
| in_op | input | 4 | Operation code (0 to 10 used) |
| in_signed | input | 1 | 1 = signed integer forms, 0 = unsigned |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| out_valid | output | 1 | Result words hold a finished operation |
| res_lo | output | 32 | Result low (even) word |
| res_hi | output | 32 | Result high (odd) word |

## Verification
A wrong partial product or a wrong sign extension in stage 1 shows at the result ports exactly two edges after the operation is issued. The error appears in the lanes fed by the faulty product. That is why every form is checked with operands whose top bits are set, under both settings of the sign input. A wrong valid bit, or a stage that keeps old data, shows in the cycle after a stream of operations ends, as a result that is non-zero or marked valid when it should not be. The back-to-back scenario checks that cycle. The rounding and saturation corners use extreme negative inputs, where wrap-around in the full-precision form and clamping in the rounded form both appear in the same result.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = WORD_W / BYTE_W;
    localparam int WIDE_W  = 2 * WORD_W;

    typedef enum logic [3:0] {
        OP_WORD     = 4'd0,
        OP_HALFWORD = 4'd1,
        OP_DUALH    = 4'd2,
        OP_DUALHW   = 4'd3,
        OP_QUADB    = 4'd4,
        OP_DOTADD   = 4'd5,
        OP_DOTSUB   = 4'd6,
        OP_DOTB     = 4'd7,
        OP_CPLX     = 4'd8,
        OP_CPLXRND  = 4'd9,
        OP_GFMUL    = 4'd10
    } mul_op_e;

    typedef struct packed {
        logic [WIDE_W-1:0]         full;
        logic [WIDE_W-1:0]         wlo;
        logic [WIDE_W-1:0]         whi;
        logic [WORD_W-1:0]         hh;
        logic [WORD_W-1:0]         ll;
        logic [WORD_W-1:0]         hl;
        logic [WORD_W-1:0]         lh;
        logic [N_BYTES*HALF_W-1:0] bprod;
        logic [WORD_W-1:0]         gf;
    } prod_t;

endpackage

// File: rtl/simd_gf8_lane.sv
module simd_gf8_lane #(
    parameter logic [7:0] POLY = 8'h1D
) (
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] p
);
    logic [7:0] acc;
    logic [7:0] sh;

    always_comb begin
        acc = '0;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? POLY : 8'h00);
        end
        p = acc;
    end

    // R10: multiplying by the field identity returns the other lane, and zero absorbs
    always_comb begin
        if (b == 8'h01) begin
            p_gf_one_r10: assert (p == a);
        end
        if (a == 8'h00) begin
            p_gf_zero_r10: assert (p == 8'h00);
        end
    end
endmodule

// File: rtl/simd_prod_stage.sv
module simd_prod_stage
    import simd_mul_pkg::*;
#(
    parameter logic [7:0] GF_POLY = 8'h1D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic              in_signed,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic              s1_valid,
    output logic [3:0]        s1_op,
    output logic              s1_signed,
    output prod_t             s1_prod
);
    prod_t prod_d;
    logic  half_s;
    logic [WORD_W-1:0] gf_w;
    logic [N_BYTES*HALF_W-1:0] byte_w;

    function automatic logic [WIDE_W-1:0] ext_w(input logic [WORD_W-1:0] x, input logic s);
        return {{WORD_W{s & x[WORD_W-1]}}, x};
    endfunction

    function automatic logic [WIDE_W-1:0] ext_h64(input logic [HALF_W-1:0] x, input logic s);
        return {{(WIDE_W-HALF_W){s & x[HALF_W-1]}}, x};
    endfunction

    function automatic logic [WORD_W-1:0] ext_h32(input logic [HALF_W-1:0] x, input logic s);
        return {{(WORD_W-HALF_W){s & x[HALF_W-1]}}, x};
    endfunction

    function automatic logic [HALF_W-1:0] ext_b(input logic [BYTE_W-1:0] x, input logic s);
        return {{(HALF_W-BYTE_W){s & x[BYTE_W-1]}}, x};
    endfunction

    // complex forms are always signed
    assign half_s = in_signed || (in_op == OP_CPLX) || (in_op == OP_CPLXRND);

    generate
        for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
            logic [BYTE_W-1:0] la, lb;
            assign la = src_a[g*BYTE_W +: BYTE_W];
            assign lb = src_b[g*BYTE_W +: BYTE_W];
            assign byte_w[g*HALF_W +: HALF_W] = ext_b(la, in_signed) * ext_b(lb, in_signed);
            simd_gf8_lane #(.POLY(GF_POLY)) u_gf (
                .a(la),
                .b(lb),
                .p(gf_w[g*BYTE_W +: BYTE_W])
            );
        end
    endgenerate

    always_comb begin
        prod_d.full  = ext_w(src_a, in_signed) * ext_w(src_b, in_signed);
        prod_d.wlo   = ext_h64(src_a[HALF_W-1:0], in_signed) * ext_w(src_b, in_signed);
        prod_d.whi   = ext_h64(src_a[WORD_W-1:HALF_W], in_signed) * ext_w(src_b, in_signed);
        prod_d.hh    = ext_h32(src_a[WORD_W-1:HALF_W], half_s) * ext_h32(src_b[WORD_W-1:HALF_W], half_s);
        prod_d.ll    = ext_h32(src_a[HALF_W-1:0], half_s) * ext_h32(src_b[HALF_W-1:0], half_s);
        prod_d.hl    = ext_h32(src_a[WORD_W-1:HALF_W], half_s) * ext_h32(src_b[HALF_W-1:0], half_s);
        prod_d.lh    = ext_h32(src_a[HALF_W-1:0], half_s) * ext_h32(src_b[WORD_W-1:HALF_W], half_s);
        prod_d.bprod = byte_w;
        prod_d.gf    = gf_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_op     <= '0;
            s1_signed <= 1'b0;
            s1_prod   <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_op     <= in_op;
            s1_signed <= in_signed;
            s1_prod   <= in_valid ? prod_d : '0;
        end
    end

    // R11: stage 1 occupancy follows the issue flag one edge later
    p_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    p_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !s1_valid);
    // R1: a zero source word yields a zero word product
    p_zero_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_WORD && src_a == '0) |=> (s1_prod.full == '0));
endmodule

// File: rtl/simd_result_fmt.sv
module simd_result_fmt
    import simd_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic [3:0]        s1_op,
    input  logic              s1_signed,
    input  prod_t             s1_prod,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_lo,
    output logic [WORD_W-1:0] res_hi
);
    mul_op_e op_e;
    logic [WORD_W-1:0] lo_d, hi_d;
    logic signed [WORD_W:0] re_x, im_x;
    logic [WORD_W-1:0] dsum;

    assign op_e = mul_op_e'(s1_op);

    function automatic logic [HALF_W-1:0] rnd_sat(input logic signed [WORD_W:0] v);
        logic signed [WORD_W+1:0] t;
        logic signed [HALF_W+1:0] q;
        t = {v[WORD_W], v} + 34'sd32768;
        q = t[WORD_W+1:HALF_W];
        if (q > 18'sd32767)       return 16'h7FFF;
        else if (q < -18'sd32768) return 16'h8000;
        else                      return q[HALF_W-1:0];
    endfunction

    always_comb begin
        re_x = $signed({s1_prod.hh[WORD_W-1], s1_prod.hh}) - $signed({s1_prod.ll[WORD_W-1], s1_prod.ll});
        im_x = $signed({s1_prod.hl[WORD_W-1], s1_prod.hl}) + $signed({s1_prod.lh[WORD_W-1], s1_prod.lh});
        dsum = '0;
        for (int k = 0; k < N_BYTES; k++) begin
            dsum = dsum + {{(WORD_W-HALF_W){s1_signed & s1_prod.bprod[k*HALF_W+HALF_W-1]}},
                           s1_prod.bprod[k*HALF_W +: HALF_W]};
        end
    end

    always_comb begin
        lo_d = '0;
        hi_d = '0;
        unique case (op_e)
            OP_WORD, OP_HALFWORD: begin
                lo_d = (op_e == OP_WORD) ? s1_prod.full[WORD_W-1:0] : s1_prod.wlo[WORD_W-1:0];
                hi_d = (op_e == OP_WORD) ? s1_prod.full[WIDE_W-1:WORD_W] : s1_prod.wlo[WIDE_W-1:WORD_W];
            end
            OP_DUALH: begin
                lo_d = s1_prod.ll;
                hi_d = s1_prod.hh;
            end
            OP_DUALHW: begin
                lo_d = s1_prod.wlo[WORD_W+HALF_W-1:HALF_W];
                hi_d = s1_prod.whi[WORD_W+HALF_W-1:HALF_W];
            end
            OP_QUADB: begin
                lo_d = s1_prod.bprod[WORD_W-1:0];
                hi_d = s1_prod.bprod[2*WORD_W-1:WORD_W];
            end
            OP_DOTADD: lo_d = s1_prod.hh + s1_prod.ll;
            OP_DOTSUB: lo_d = s1_prod.hh - s1_prod.ll;
            OP_DOTB:   lo_d = dsum;
            OP_CPLX: begin
                lo_d = re_x[WORD_W-1:0];
                hi_d = im_x[WORD_W-1:0];
            end
            OP_CPLXRND: lo_d = {rnd_sat(re_x), rnd_sat(im_x)};
            OP_GFMUL:   lo_d = s1_prod.gf;
            default: begin
                lo_d = '0;
                hi_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_lo    <= '0;
            res_hi    <= '0;
        end else begin
            out_valid <= s1_valid;
            res_lo    <= s1_valid ? lo_d : '0;
            res_hi    <= s1_valid ? hi_d : '0;
        end
    end

    // R11: stage 2 follows stage 1 and clears when nothing arrives
    p_flow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> (!out_valid && res_lo == '0 && res_hi == '0));
endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
    import simd_mul_pkg::*;
#(
    parameter logic [7:0] GF_POLY = 8'h1D
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [3:0]  in_op,
    input  logic        in_signed,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    output logic        out_valid,
    output logic [31:0] res_lo,
    output logic [31:0] res_hi
);
    logic        s1_valid;
    logic [3:0]  s1_op;
    logic        s1_signed;
    prod_t       s1_prod;

    simd_prod_stage #(.GF_POLY(GF_POLY)) u_prod (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_signed (in_signed),
        .src_a     (src_a),
        .src_b     (src_b),
        .s1_valid  (s1_valid),
        .s1_op     (s1_op),
        .s1_signed (s1_signed),
        .s1_prod   (s1_prod)
    );

    simd_result_fmt u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_op     (s1_op),
        .s1_signed (s1_signed),
        .s1_prod   (s1_prod),
        .out_valid (out_valid),
        .res_lo    (res_lo),
        .res_hi    (res_hi)
    );

    // R11: end-to-end latency of two edges
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    // R12: reserved codes produce an all-zero result
    p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > 4'd10) |-> ##2 (res_lo == '0 && res_hi == '0));
endmodule

// File: tb/simd_mul_unit_test.sv
module simd_mul_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  in_op;
    logic        in_signed;
    logic [31:0] src_a, src_b;
    logic        out_valid;
    logic [31:0] res_lo, res_hi;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    simd_mul_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_signed(in_signed), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi)
    );

    function automatic longint xw(logic [31:0] x, bit s);
        return s ? longint'(int'(x)) : longint'({32'b0, x});
    endfunction
    function automatic longint xh(logic [15:0] x, bit s);
        return s ? longint'(shortint'(x)) : longint'({48'b0, x});
    endfunction
    function automatic longint xb(logic [7:0] x, bit s);
        return s ? longint'(byte'(x)) : longint'({56'b0, x});
    endfunction
    function automatic logic [7:0] gfm(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        logic [7:0] y = b;
        while (y != 0) begin
            if (y[0]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
            y = y >> 1;
        end
        return r;
    endfunction
    function automatic logic [15:0] rs(longint v);
        longint q = (v + 32768) >>> 16;
        if (q > 32767) return 16'h7FFF;
        if (q < -32768) return 16'h8000;
        return q[15:0];
    endfunction

    function automatic logic [63:0] model(logic [3:0] op, bit s, logic [31:0] a, logic [31:0] b);
        longint p, q, re, im, sum;
        logic [63:0] r = 0;
        case (op)
            4'd0: r = xw(a, s) * xw(b, s);
            4'd1: r = xh(a[15:0], s) * xw(b, s);
            4'd2: begin
                p = xh(a[15:0], s) * xh(b[15:0], s);
                q = xh(a[31:16], s) * xh(b[31:16], s);
                r = {q[31:0], p[31:0]};
            end
            4'd3: begin
                p = xh(a[15:0], s) * xw(b, s);
                q = xh(a[31:16], s) * xw(b, s);
                r = {q[47:16], p[47:16]};
            end
            4'd4: for (int k = 0; k < 4; k++) begin
                p = xb(a[8*k +: 8], s) * xb(b[8*k +: 8], s);
                r[16*k +: 16] = p[15:0];
            end
            4'd5, 4'd6: begin
                p = xh(a[31:16], s) * xh(b[31:16], s);
                q = xh(a[15:0], s) * xh(b[15:0], s);
                sum = (op == 4'd5) ? p + q : p - q;
                r = {32'b0, sum[31:0]};
            end
            4'd7: begin
                sum = 0;
                for (int k = 0; k < 4; k++) sum += xb(a[8*k +: 8], s) * xb(b[8*k +: 8], s);
                r = {32'b0, sum[31:0]};
            end
            4'd8, 4'd9: begin
                re = xh(a[31:16], 1) * xh(b[31:16], 1) - xh(a[15:0], 1) * xh(b[15:0], 1);
                im = xh(a[31:16], 1) * xh(b[15:0], 1) + xh(a[15:0], 1) * xh(b[31:16], 1);
                if (op == 4'd8) r = {im[31:0], re[31:0]};
                else r = {32'b0, rs(re), rs(im)};
            end
            4'd10: for (int k = 0; k < 4; k++) r[8*k +: 8] = gfm(a[8*k +: 8], b[8*k +: 8]);
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one op at a negedge, sample two edges later at a negedge
    task automatic run_one(string req, logic [3:0] op, bit s, logic [31:0] a, logic [31:0] b,
                           logic [63:0] exp);
        in_valid = 1'b1; in_op = op; in_signed = s; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({req, " valid"}, {63'b0, out_valid}, 64'd1);
        chk(req, {res_hi, res_lo}, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b1; in_op = 4'd0; in_signed = 1'b0;
        src_a = 32'hFFFF_FFFF; src_b = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk("R13 reset", {res_hi, res_lo}, 64'd0);
        chk("R13 reset valid", {63'b0, out_valid}, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_word;
        run_one("R1 signed -1*-1", 4'd0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0000_0000_0000_0001);
        run_one("R1 unsigned max*max", 4'd0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFE_0000_0001);
        run_one("R1 signed mixed", 4'd0, 1, 32'h8000_0000, 32'h0000_0003,
                model(4'd0, 1, 32'h8000_0000, 32'h0000_0003));
    endtask

    task automatic t_halfword;
        run_one("R2 signed", 4'd1, 1, 32'h1234_8001, 32'h9000_0005, model(4'd1, 1, 32'h1234_8001, 32'h9000_0005));
        run_one("R2 unsigned", 4'd1, 0, 32'h1234_8001, 32'h9000_0005, model(4'd1, 0, 32'h1234_8001, 32'h9000_0005));
    endtask

    task automatic t_dual;
        run_one("R3 signed", 4'd2, 1, 32'hFFFE_0003, 32'h0004_FFF9, model(4'd2, 1, 32'hFFFE_0003, 32'h0004_FFF9));
        run_one("R3 unsigned", 4'd2, 0, 32'hFFFF_8000, 32'hFFFF_8000, model(4'd2, 0, 32'hFFFF_8000, 32'hFFFF_8000));
        run_one("R4 signed", 4'd3, 1, 32'h8000_7FFF, 32'hDEAD_BEEF, model(4'd3, 1, 32'h8000_7FFF, 32'hDEAD_BEEF));
        run_one("R4 unsigned", 4'd3, 0, 32'h8000_7FFF, 32'hDEAD_BEEF, model(4'd3, 0, 32'h8000_7FFF, 32'hDEAD_BEEF));
    endtask

    task automatic t_quad;
        run_one("R5 signed", 4'd4, 1, 32'h80FF_7F02, 32'h80FF_81FD, model(4'd4, 1, 32'h80FF_7F02, 32'h80FF_81FD));
        run_one("R5 unsigned", 4'd4, 0, 32'h80FF_7F02, 32'h80FF_81FD, model(4'd4, 0, 32'h80FF_7F02, 32'h80FF_81FD));
    endtask

    task automatic t_dot;
        run_one("R6 add signed", 4'd5, 1, 32'hFFFD_0007, 32'h0005_FFFE, model(4'd5, 1, 32'hFFFD_0007, 32'h0005_FFFE));
        run_one("R6 sub unsigned", 4'd6, 0, 32'h0002_FFFF, 32'h0003_FFFF, model(4'd6, 0, 32'h0002_FFFF, 32'h0003_FFFF));
        run_one("R7 signed", 4'd7, 1, 32'h8080_FF01, 32'h807F_02FF, model(4'd7, 1, 32'h8080_FF01, 32'h807F_02FF));
        run_one("R7 unsigned", 4'd7, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0003_F804);
    endtask

    task automatic t_cplx;
        run_one("R8 general", 4'd8, 0, 32'h0003_FFFE, 32'hFFFB_0004, model(4'd8, 0, 32'h0003_FFFE, 32'hFFFB_0004));
        run_one("R8 wrap corner", 4'd8, 1, 32'h8000_8000, 32'h8000_8000, 64'h8000_0000_0000_0000);
        run_one("R9 saturate corner", 4'd9, 0, 32'h8000_8000, 32'h8000_8000, 64'h0000_0000_0000_7FFF);
        run_one("R9 rounding", 4'd9, 1, 32'h1234_C000, 32'h7FFF_0101, model(4'd9, 1, 32'h1234_C000, 32'h7FFF_0101));
        run_one("R9 negative round", 4'd9, 1, 32'h0001_0000, 32'hFFFF_0000, 64'h0000_0000_0000_0000);
    endtask

    task automatic t_gf;
        run_one("R10 reduce", 4'd10, 0, 32'h8002_0157, 32'h0253_FF83, model(4'd10, 0, 32'h8002_0157, 32'h0253_FF83));
        run_one("R10 literal", 4'd10, 1, 32'h0000_0080, 32'h0000_0002, 64'h0000_0000_0000_001D);
    endtask

    task automatic t_reserved;
        run_one("R12 op 11", 4'd11, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0);
        run_one("R12 op 15", 4'd15, 0, 32'h1234_5678, 32'h9ABC_DEF0, 64'd0);
    endtask

    // R11: back-to-back issue, then idle with cleared outputs
    task automatic t_stream;
        logic [3:0]  ops [4] = '{4'd0, 4'd8, 4'd10, 4'd4};
        logic [31:0] av  [4] = '{32'hCAFE_0001, 32'h7FFF_8001, 32'hA5A5_5A5A, 32'h0102_FF80};
        logic [31:0] bv  [4] = '{32'h0BAD_F00D, 32'h0002_7FFF, 32'h3C3C_C3C3, 32'hFE03_7F80};
        logic [63:0] ev  [4];
        for (int i = 0; i < 4; i++) ev[i] = model(ops[i], 1, av[i], bv[i]);
        for (int n = 0; n < 7; n++) begin
            if (n >= 2 && n < 6) begin
                chk("R11 stream valid", {63'b0, out_valid}, 64'd1);
                chk("R11 stream data", {res_hi, res_lo}, ev[n-2]);
            end else if (n == 6) begin
                chk("R11 idle valid", {63'b0, out_valid}, 64'd0);
                chk("R11 idle data", {res_hi, res_lo}, 64'd0);
            end
            if (n < 4) begin
                in_valid = 1'b1; in_op = ops[n]; in_signed = 1'b1; src_a = av[n]; src_b = bv[n];
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_word();
        t_halfword();
        t_dual();
        t_quad();
        t_dot();
        t_cplx();
        t_gf();
        t_reserved();
        t_stream();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule